// File: doc/BRIEF.md
# Configuration Address/Data Port Decoder

This block is an I/O-space slave that gives a host access to configuration space through two ports. The first is a 32-bit address port (0xCF8). A dword write to it loads a configuration address. That address holds an enable flag, a bus number, a device number, a function number and a register offset. The second is a four-byte data window (0xCFC to 0xCFF). An access to the window becomes a single request on a configuration-space backend. The request carries the register offset, the access size, the direction and the write data.

Only one bus/device/function triple is served, and input straps select it. An access aimed at any other triple never reaches the backend. A read of such a target returns zero. The backend answers reads combinationally in the same cycle as the request. The block narrows the answer to the access size before it returns it to the host.

Host accesses are single-cycle: `io_valid` marks a cycle that carries one access. The address register is the only state in the block.

Top module: `cfg_port_decoder`

## Requirements
- R1: A dword (`io_size`=2) write to port 0xCF8 loads the configuration address with the written value ANDed with 0x80FFFFFC. This clears bits 30:24 and bits 1:0.
- R2: A dword read of port 0xCF8 returns the stored configuration address. Byte or word accesses to 0xCF8 neither load it nor return it: they read as 0.
- R3: A data-window access raises `be_req` only when bit 31 of the configuration address is 1. While bit 31 is 0, reads of the window return 0 and writes are dropped.
- R4: Byte (`io_size`=0) and word (`io_size`=1) accesses are accepted at any port from 0xCFC to 0xCFF. Their `be_offset` is address bits 7:0 plus (port − 0xCFC), taken modulo 256.
- R5: Dword accesses to the window are accepted only at port 0xCFC, with `be_offset` equal to address bits 7:0. A dword access at 0xCFD–0xCFF, or at any port outside both port ranges, makes no request and reads 0.
- R6: The function number is taken from address bits 10:8, the device from bits 15:11 and the bus from bits 23:16. A request is made only when all three equal `tgt_func`, `tgt_dev` and `tgt_bus`. Non-matching reads return 0.
- R7: On a request, `be_size` equals `io_size` (0 byte, 1 word, 2 dword), `be_we` equals `io_write` and `be_wdata` equals `io_wdata`. Size code 3 is never forwarded and reads 0.
- R8: Forwarded read data is zero-extended. A byte read returns `be_rdata[7:0]`, a word read returns `be_rdata[15:0]` and a dword read returns all 32 bits. Every host write returns `io_rdata` = 0.
- R9: Synchronous reset clears the configuration address to 0, which disables the data window.
- R10: `be_req` is asserted only in a cycle with `io_valid` high. The request and its read data are combinational within that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_valid | input | 1 | Host access present this cycle |
| io_write | input | 1 | 1 = host write, 0 = host read |
| io_port | input | 16 | Host I/O port number |
| io_size | input | 2 | Access size: 0 byte, 1 word, 2 dword, 3 invalid |
| io_wdata | input | 32 | Host write data |
| io_rdata | output | 32 | Host read data, combinational |
| tgt_bus | input | 8 | Strap: served bus number |
| tgt_dev | input | 5 | Strap: served device number |
| tgt_func | input | 3 | Strap: served function number |
| be_req | output | 1 | Backend request strobe |
| be_we | output | 1 | Backend request is a write |
| be_size | output | 2 | Backend access size, same code as `io_size` |
| be_offset | output | 8 | Backend register byte offset |
| be_wdata | output | 32 | Backend write data |
| be_rdata | input | 32 | Backend read data, same cycle as the request |

## Verification
The assertions assume three things about the inputs:
- The host fields are stable for the whole cycle in which `io_valid` is high.
- The target straps do not change while requests can be made.
- `be_rdata` is a pure function of the request lines.

The bench changes host inputs only on the falling clock edge, holds the straps constant for the whole run, and models the backend as a combinational function of `be_offset`. With a fixed backend model, every expected read value can be computed from the offset alone. The stimulus includes the corner values that the properties depend on: invalid size code 3, dword accesses off 0xCFC, a mismatch in each of bus, device and function, and a register offset at 0xFC–0xFF, the top of the 8-bit range.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

    localparam int CFG_W  = 32;
    localparam int BUS_W  = 8;
    localparam int DEV_W  = 5;
    localparam int FUNC_W = 3;
    localparam int OFF_W  = 8;
    localparam int LANES  = CFG_W / 8;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2,
        SZ_RSVD  = 2'd3
    } acc_size_e;

    // Field positions are architectural: the filter decodes them.
    typedef struct packed {
        logic              en;
        logic [6:0]        rsvd;
        logic [BUS_W-1:0]  bus;
        logic [DEV_W-1:0]  dev;
        logic [FUNC_W-1:0] func;
        logic [OFF_W-1:0]  reg_off;
    } cfg_addr_t;

    // Whether byte lane b survives zero-extension for a given size.
    function automatic logic lane_kept(acc_size_e sz, int b);
        case (sz)
            SZ_BYTE:  return (b == 0);
            SZ_WORD:  return (b < 2);
            SZ_DWORD: return 1'b1;
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/cfgp_addr_reg.sv
module cfgp_addr_reg
    import cfgp_pkg::*;
#(
    parameter logic [CFG_W-1:0] KEEP_MASK = 32'h80FF_FFFC
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CFG_W-1:0] wdata,
    output cfg_addr_t        q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (load) begin
            q <= cfg_addr_t'(wdata & KEEP_MASK);
        end
    end

endmodule

// File: rtl/cfgp_port_decode.sv
module cfgp_port_decode
    import cfgp_pkg::*;
#(
    parameter int              PORT_W    = 16,
    parameter logic [PORT_W-1:0] ADDR_PORT = 16'hCF8,
    parameter logic [PORT_W-1:0] DATA_PORT = 16'hCFC
) (
    input  logic              valid,
    input  logic              write,
    input  logic [PORT_W-1:0] port,
    input  acc_size_e         size,
    output logic              addr_wr,
    output logic              addr_rd,
    output logic              data_hit,
    output logic [1:0]        lane
);

    localparam logic [PORT_W-1:0] DATA_LAST = DATA_PORT + PORT_W'(LANES - 1);

    logic is_dword;
    logic size_ok;
    logic in_window;
    logic at_addr;

    always_comb begin
        is_dword  = (size == SZ_DWORD);
        size_ok   = (size != SZ_RSVD);
        in_window = (port >= DATA_PORT) && (port <= DATA_LAST);
        at_addr   = (port == ADDR_PORT);
        lane      = 2'(port[1:0] - DATA_PORT[1:0]);

        addr_wr   = valid &&  write && is_dword && at_addr;
        addr_rd   = valid && !write && is_dword && at_addr;
        data_hit  = valid && size_ok &&
                    (is_dword ? (port == DATA_PORT) : in_window);
    end

endmodule

// File: rtl/cfgp_target_filter.sv
module cfgp_target_filter
    import cfgp_pkg::*;
(
    input  logic              data_hit,
    input  logic              write,
    input  acc_size_e         size,
    input  logic [CFG_W-1:0]  wdata,
    input  logic              en,
    input  logic [BUS_W-1:0]  bus,
    input  logic [DEV_W-1:0]  dev,
    input  logic [FUNC_W-1:0] func,
    input  logic [OFF_W-1:0]  reg_off,
    input  logic [1:0]        lane,
    input  logic [BUS_W-1:0]  tgt_bus,
    input  logic [DEV_W-1:0]  tgt_dev,
    input  logic [FUNC_W-1:0] tgt_func,
    output logic              req,
    output logic              we,
    output acc_size_e         size_o,
    output logic [OFF_W-1:0]  offset,
    output logic [CFG_W-1:0]  wdata_o,
    output logic              rd_fwd
);

    logic match;

    always_comb begin
        match   = (bus == tgt_bus) && (dev == tgt_dev) && (func == tgt_func);
        req     = data_hit && en && match;
        we      = req && write;
        rd_fwd  = req && !write;
        size_o  = size;
        offset  = OFF_W'(reg_off + {{(OFF_W-2){1'b0}}, lane});
        wdata_o = wdata;
    end

endmodule

// File: rtl/cfg_port_decoder.sv
module cfg_port_decoder
    import cfgp_pkg::*;
#(
    parameter int                PORT_W    = 16,
    parameter logic [PORT_W-1:0] ADDR_PORT = 16'hCF8,
    parameter logic [PORT_W-1:0] DATA_PORT = 16'hCFC,
    parameter logic [CFG_W-1:0]  KEEP_MASK = 32'h80FF_FFFC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              io_valid,
    input  logic              io_write,
    input  logic [PORT_W-1:0] io_port,
    input  logic [1:0]        io_size,
    input  logic [CFG_W-1:0]  io_wdata,
    output logic [CFG_W-1:0]  io_rdata,
    input  logic [BUS_W-1:0]  tgt_bus,
    input  logic [DEV_W-1:0]  tgt_dev,
    input  logic [FUNC_W-1:0] tgt_func,
    output logic              be_req,
    output logic              be_we,
    output logic [1:0]        be_size,
    output logic [OFF_W-1:0]  be_offset,
    output logic [CFG_W-1:0]  be_wdata,
    input  logic [CFG_W-1:0]  be_rdata
);

    acc_size_e  size_e;
    acc_size_e  be_size_e;
    cfg_addr_t  cfg_addr_q;
    logic       addr_wr;
    logic       addr_rd;
    logic       data_hit;
    logic [1:0] lane;
    logic       rd_fwd;
    logic [CFG_W-1:0] fwd_data;

    assign size_e  = acc_size_e'(io_size);
    assign be_size = be_size_e;

    cfgp_port_decode #(
        .PORT_W    (PORT_W),
        .ADDR_PORT (ADDR_PORT),
        .DATA_PORT (DATA_PORT)
    ) u_decode (
        .valid    (io_valid),
        .write    (io_write),
        .port     (io_port),
        .size     (size_e),
        .addr_wr  (addr_wr),
        .addr_rd  (addr_rd),
        .data_hit (data_hit),
        .lane     (lane)
    );

    cfgp_addr_reg #(
        .KEEP_MASK (KEEP_MASK)
    ) u_addr (
        .clk   (clk),
        .rst   (rst),
        .load  (addr_wr),
        .wdata (io_wdata),
        .q     (cfg_addr_q)
    );

    cfgp_target_filter u_filter (
        .data_hit (data_hit),
        .write    (io_write),
        .size     (size_e),
        .wdata    (io_wdata),
        .en       (cfg_addr_q.en),
        .bus      (cfg_addr_q.bus),
        .dev      (cfg_addr_q.dev),
        .func     (cfg_addr_q.func),
        .reg_off  (cfg_addr_q.reg_off),
        .lane     (lane),
        .tgt_bus  (tgt_bus),
        .tgt_dev  (tgt_dev),
        .tgt_func (tgt_func),
        .req      (be_req),
        .we       (be_we),
        .size_o   (be_size_e),
        .offset   (be_offset),
        .wdata_o  (be_wdata),
        .rd_fwd   (rd_fwd)
    );

    // Zero-extension of backend read data, one byte lane per slice.
    for (genvar b = 0; b < LANES; b++) begin : g_zext
        assign fwd_data[8*b +: 8] = lane_kept(size_e, b) ? be_rdata[8*b +: 8] : 8'h00;
    end

    always_comb begin
        if (addr_rd) begin
            io_rdata = cfg_addr_q;
        end else if (rd_fwd) begin
            io_rdata = fwd_data;
        end else begin
            io_rdata = '0;
        end
    end

endmodule

// File: rtl/cfgp_checker.sv
module cfgp_checker
    import cfgp_pkg::*;
#(
    parameter int                PORT_W    = 16,
    parameter logic [PORT_W-1:0] ADDR_PORT = 16'hCF8,
    parameter logic [PORT_W-1:0] DATA_PORT = 16'hCFC,
    parameter logic [CFG_W-1:0]  KEEP_MASK = 32'h80FF_FFFC
) (
    input logic              clk,
    input logic              rst,
    input logic              io_valid,
    input logic              io_write,
    input logic [PORT_W-1:0] io_port,
    input logic [1:0]        io_size,
    input logic [CFG_W-1:0]  io_wdata,
    input logic [CFG_W-1:0]  io_rdata,
    input logic [BUS_W-1:0]  tgt_bus,
    input logic [DEV_W-1:0]  tgt_dev,
    input logic [FUNC_W-1:0] tgt_func,
    input logic              be_req,
    input logic              be_we,
    input logic [1:0]        be_size,
    input logic [OFF_W-1:0]  be_offset,
    input logic [CFG_W-1:0]  cfg_addr
);

    logic addr_load;
    logic addr_read;
    logic win_read;

    assign addr_load = io_valid && io_write && io_port == ADDR_PORT && io_size == 2'd2;
    assign addr_read = io_valid && !io_write && io_port == ADDR_PORT && io_size == 2'd2;
    assign win_read  = io_valid && !io_write && io_port >= DATA_PORT &&
                       io_port <= DATA_PORT + PORT_W'(3);

    p_addr_load_r1: assert property (@(posedge clk) disable iff (rst)
        addr_load |=> cfg_addr == ($past(io_wdata) & KEEP_MASK));

    p_addr_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !addr_load |=> $stable(cfg_addr));

    p_addr_read_r2: assert property (@(posedge clk) disable iff (rst)
        addr_read |-> io_rdata == cfg_addr);

    p_gate_r3: assert property (@(posedge clk) disable iff (rst)
        be_req |-> cfg_addr[31]);

    p_read_off_r3: assert property (@(posedge clk) disable iff (rst)
        (win_read && !cfg_addr[31]) |-> io_rdata == '0);

    p_sub_offset_r4: assert property (@(posedge clk) disable iff (rst)
        (be_req && be_size != 2'd2) |->
        be_offset == OFF_W'(cfg_addr[7:0] + 8'(io_port - DATA_PORT)));

    p_dword_port_r5: assert property (@(posedge clk) disable iff (rst)
        (be_req && be_size == 2'd2) |->
        (io_port == DATA_PORT && be_offset == cfg_addr[7:0]));

    p_target_r6: assert property (@(posedge clk) disable iff (rst)
        be_req |-> (cfg_addr[23:16] == tgt_bus && cfg_addr[15:11] == tgt_dev &&
                    cfg_addr[10:8] == tgt_func));

    p_pass_r7: assert property (@(posedge clk) disable iff (rst)
        be_req |-> (be_size == io_size && be_we == io_write && io_size != 2'd3));

    p_zext_r8: assert property (@(posedge clk) disable iff (rst)
        (be_req && !io_write && be_size == 2'd0) |-> io_rdata[31:8] == '0);

    p_write_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (io_valid && io_write) |-> io_rdata == '0);

    p_reset_r9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> cfg_addr == '0);

    p_valid_r10: assert property (@(posedge clk) disable iff (rst)
        be_req |-> io_valid);

endmodule

bind cfg_port_decoder cfgp_checker #(
    .PORT_W    (PORT_W),
    .ADDR_PORT (ADDR_PORT),
    .DATA_PORT (DATA_PORT),
    .KEEP_MASK (KEEP_MASK)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .io_valid  (io_valid),
    .io_write  (io_write),
    .io_port   (io_port),
    .io_size   (io_size),
    .io_wdata  (io_wdata),
    .io_rdata  (io_rdata),
    .tgt_bus   (tgt_bus),
    .tgt_dev   (tgt_dev),
    .tgt_func  (tgt_func),
    .be_req    (be_req),
    .be_we     (be_we),
    .be_size   (be_size),
    .be_offset (be_offset),
    .cfg_addr  (cfg_addr_q)
);

// File: tb/sim_cfg_port_decoder.sv
module sim_cfg_port_decoder;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 31;

    typedef struct packed {
        logic        wr;
        logic [15:0] port;
        logic [1:0]  size;
        logic [31:0] wdata;
        logic        req;
        logic [7:0]  off;
        logic [31:0] rdata;
        logic [3:0]  rq;
    } vec_t;

    // size: 0 byte, 1 word, 2 dword. Straps: bus 02, dev 05, func 3.
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 16'hCF8, 2'd2, 32'hFFFF_FFFF, 1'b0, 8'h00, 32'h0,          4'd1},
        '{1'b0, 16'hCF8, 2'd2, 32'h0,         1'b0, 8'h00, 32'h80FF_FFFC,  4'd2},
        '{1'b1, 16'hCF8, 2'd2, 32'h8002_2B13, 1'b0, 8'h00, 32'h0,          4'd1},
        '{1'b0, 16'hCF8, 2'd2, 32'h0,         1'b0, 8'h00, 32'h8002_2B10,  4'd2},
        '{1'b0, 16'hCFC, 2'd2, 32'h0,         1'b1, 8'h10, 32'hEF21_4A10,  4'd5},
        '{1'b0, 16'hCFE, 2'd0, 32'h0,         1'b1, 8'h12, 32'h0000_0012,  4'd4},
        '{1'b0, 16'hCFD, 2'd1, 32'h0,         1'b1, 8'h11, 32'h0000_4B11,  4'd8},
        '{1'b0, 16'hCFF, 2'd0, 32'h0,         1'b1, 8'h13, 32'h0000_0013,  4'd4},
        '{1'b0, 16'hCFD, 2'd2, 32'h0,         1'b0, 8'h00, 32'h0,          4'd5},
        '{1'b1, 16'hCFE, 2'd1, 32'h1234_ABCD, 1'b1, 8'h12, 32'h0,          4'd7},
        '{1'b1, 16'hCF8, 2'd0, 32'h0,         1'b0, 8'h00, 32'h0,          4'd2},
        '{1'b0, 16'hCF8, 2'd2, 32'h0,         1'b0, 8'h00, 32'h8002_2B10,  4'd2},
        '{1'b0, 16'hCF8, 2'd1, 32'h0,         1'b0, 8'h00, 32'h0,          4'd2},
        '{1'b1, 16'hCF8, 2'd2, 32'h8003_2B10, 1'b0, 8'h00, 32'h0,          4'd1},
        '{1'b0, 16'hCFC, 2'd2, 32'h0,         1'b0, 8'h00, 32'h0,          4'd6},
        '{1'b1, 16'hCF8, 2'd2, 32'h8002_2A10, 1'b0, 8'h00, 32'h0,          4'd1},
        '{1'b0, 16'hCFC, 2'd0, 32'h0,         1'b0, 8'h00, 32'h0,          4'd6},
        '{1'b1, 16'hCF8, 2'd2, 32'h8002_3310, 1'b0, 8'h00, 32'h0,          4'd1},
        '{1'b0, 16'hCFC, 2'd1, 32'h0,         1'b0, 8'h00, 32'h0,          4'd6},
        '{1'b1, 16'hCF8, 2'd2, 32'h7F02_2B40, 1'b0, 8'h00, 32'h0,          4'd1},
        '{1'b0, 16'hCF8, 2'd2, 32'h0,         1'b0, 8'h00, 32'h0002_2B40,  4'd1},
        '{1'b0, 16'hCFC, 2'd2, 32'h0,         1'b0, 8'h00, 32'h0,          4'd3},
        '{1'b1, 16'hCFC, 2'd0, 32'h0000_00AA, 1'b0, 8'h00, 32'h0,          4'd3},
        '{1'b1, 16'hCF8, 2'd2, 32'h8002_2BFC, 1'b0, 8'h00, 32'h0,          4'd1},
        '{1'b0, 16'hCFF, 2'd0, 32'h0,         1'b1, 8'hFF, 32'h0000_00FF,  4'd4},
        '{1'b0, 16'hCFE, 2'd1, 32'h0,         1'b1, 8'hFE, 32'h0000_A4FE,  4'd8},
        '{1'b0, 16'hCFC, 2'd2, 32'h0,         1'b1, 8'hFC, 32'h030D_A6FC,  4'd5},
        '{1'b0, 16'hCFC, 2'd3, 32'h0,         1'b0, 8'h00, 32'h0,          4'd7},
        '{1'b0, 16'h03C0, 2'd2, 32'h0,        1'b0, 8'h00, 32'h0,          4'd5},
        '{1'b1, 16'hCFC, 2'd2, 32'hCAFE_F00D, 1'b1, 8'hFC, 32'h0,          4'd7},
        '{1'b1, 16'hCFF, 2'd2, 32'h5555_5555, 1'b0, 8'h00, 32'h0,          4'd5}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        io_valid = 1'b0;
    logic        io_write = 1'b0;
    logic [15:0] io_port = '0;
    logic [1:0]  io_size = '0;
    logic [31:0] io_wdata = '0;
    logic [31:0] io_rdata;
    logic [7:0]  tgt_bus  = 8'h02;
    logic [4:0]  tgt_dev  = 5'h05;
    logic [2:0]  tgt_func = 3'h3;
    logic        be_req;
    logic        be_we;
    logic [1:0]  be_size;
    logic [7:0]  be_offset;
    logic [31:0] be_wdata;
    logic [31:0] be_rdata;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Backend model: read data is a fixed function of the offset.
    assign be_rdata = {~be_offset, 8'(be_offset + 8'h11), be_offset ^ 8'h5A, be_offset};

    cfg_port_decoder u0 (
        .clk(clk), .rst(rst),
        .io_valid(io_valid), .io_write(io_write), .io_port(io_port),
        .io_size(io_size), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .tgt_bus(tgt_bus), .tgt_dev(tgt_dev), .tgt_func(tgt_func),
        .be_req(be_req), .be_we(be_we), .be_size(be_size),
        .be_offset(be_offset), .be_wdata(be_wdata), .be_rdata(be_rdata)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // One host access: drive on the falling edge, sample before the rising edge.
    task automatic access(input logic wr, input logic [15:0] port, input logic [1:0] size,
                          input logic [31:0] wdata, input logic exp_req,
                          input logic [7:0] exp_off, input logic [31:0] exp_rd,
                          input string tag);
        @(negedge clk);
        io_valid = 1'b1;
        io_write = wr;
        io_port  = port;
        io_size  = size;
        io_wdata = wdata;
        #1;
        check(tag, "be_req", {31'b0, be_req}, {31'b0, exp_req});
        if (exp_req && be_req) begin
            check(tag, "be_offset", {24'b0, be_offset}, {24'b0, exp_off});
            check("R7", "be_size", {30'b0, be_size}, {30'b0, size});
            check("R7", "be_we", {31'b0, be_we}, {31'b0, wr});
            if (wr) check("R7", "be_wdata", be_wdata, wdata);
        end
        check(tag, "io_rdata", io_rdata, exp_rd);
        @(posedge clk);
        #1;
        io_valid = 1'b0;
        io_write = 1'b0;
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 20000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R9: address is zero after reset, window disabled (R3).
        access(1'b0, 16'hCF8, 2'd2, 32'h0, 1'b0, 8'h00, 32'h0, "R9");
        access(1'b0, 16'hCFC, 2'd2, 32'h0, 1'b0, 8'h00, 32'h0, "R3");

        for (int i = 0; i < NVEC; i++) begin
            access(VECS[i].wr, VECS[i].port, VECS[i].size, VECS[i].wdata,
                   VECS[i].req, VECS[i].off, VECS[i].rdata,
                   $sformatf("R%0d", VECS[i].rq));
        end

        // R10: idle cycle with a data-window address on the bus makes no request.
        @(negedge clk);
        io_valid = 1'b0;
        io_port  = 16'hCFC;
        io_size  = 2'd2;
        #1;
        check("R10", "idle be_req", {31'b0, be_req}, 32'h0);

        // R9: reset mid-run clears an enabled address.
        access(1'b1, 16'hCF8, 2'd2, 32'h8002_2B00, 1'b0, 8'h00, 32'h0, "R1");
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1 rst = 1'b0;
        access(1'b0, 16'hCF8, 2'd2, 32'h0, 1'b0, 8'h00, 32'h0, "R9");
        access(1'b0, 16'hCFC, 2'd0, 32'h0, 1'b0, 8'h00, 32'h0, "R9");

        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule